// File: doc/BRIEF.md
# Transmit Path Bit-Compare Supervisor

This block sits between a serial protocol controller and a single-wire bus driver and decides, cycle by cycle, whether the controller's transmit data may reach the bus. It watches two fault conditions. The first is a disagreement between the level the controller sends and the level it reads back from the bus. The second is a transmit line that stays low far longer than any legal bit. Either fault withdraws the driver enable. The path comes back only after both the transmit line and the bus have been idle-high for a set time. The receive direction is not touched.

A bidirectional status pin is modelled as a pair of inputs (a "driven" flag and a driven value) plus one status output. While the pin is driven from outside, its value forces the path on (0) or off (1) and both automatic checks are suspended. While it is released, the status output reports the path state. All inputs are asynchronous to the clock and pass through synchronizers. Every time window is a parameter in clock cycles.

Top module: `txgate_supervisor`

## Requirements
- R1: While reset is asserted, and right after reset is released, `drv_en` is 0 and `status_out` is 1. The path stays disabled until the enable condition of R4 is met.
- R2: `status_out` is always the inverse of `drv_en`. A status of 0 means transmission is enabled and 1 means it is disabled.
- R3: With no override, if the synchronized transmit and bus levels differ on CMP_CYC consecutive clock samples, `drv_en` drops to 0. A disagreement lasting CMP_CYC-1 samples leaves it at 1.
- R4: With no override and the path disabled, `drv_en` rises to 1 once transmit and bus are both high on ENA_CYC consecutive samples. ENA_CYC-1 samples are not enough.
- R5: With no override, a falling edge on transmit arms a low timer. When transmit has been low for LOW_CYC accumulated samples, `drv_en` drops to 0. LOW_CYC-1 samples followed by a recovery keep it at 1.
- R6: A transmit high pulse of at least REC_CYC samples clears the low timer and disarms it. A shorter high pulse leaves the accumulated low time in place, and further low samples add to it.
- R7: While `ovr_valid` is 1, `ovr_value`=0 forces `drv_en` to 1 even under a mismatch or a stuck-low transmit. `ovr_value`=1 forces `drv_en` to 0 even when transmit and bus are idle-high.
- R8: When the override is released, the path keeps the state the override left it in. All check timers restart from zero at release, so a fault present at release needs a full CMP_CYC window before it disables the path.
- R9: Each input passes SYNC_STAGES flip-flops. An override change applied just before a clock edge shows on `drv_en` after exactly SYNC_STAGES+1 rising edges; with the default of 2, that is the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | 1 | Transmit data from the protocol controller |
| bus_in | input | 1 | Bus level read back by the receiver comparator |
| ovr_valid | input | 1 | 1 while the status pin is driven from outside |
| ovr_value | input | 1 | Level driven on the status pin (0 force on, 1 force off) |
| drv_en | output | 1 | Enable for the bus driver (1 = transmission allowed) |
| status_out | output | 1 | Status pin output (0 enabled, 1 disabled) |

## Verification
The bench drives each fault for exactly one sample less than its window and then exactly its window. A design that is off by one in any counter disables too early or one cycle late, and one of the two boundary checks catches it. It also sends a sub-recovery high pulse through the middle of a stuck-low period, so a design that clears the low timer on any high sample never disables. A full-width recovery pulse is sent as well, so a design that never clears the timer disables wrongly. Override release is tested both with a persisting mismatch and with an idle bus: a design that keeps counting during the override, or that drops the forced state at release, changes `drv_en` at the wrong edge. The override latency is checked on both sides of the third edge.

// File: rtl/txg_pkg.sv
package txg_pkg;

    // Synchronized view of the asynchronous inputs
    typedef struct packed {
        logic ovr_val;
        logic ovr_v;
        logic bus;
        logic tx;
    } txg_in_t;

    localparam int TXG_IN_W = $bits(txg_in_t);

    // Registered control outputs
    typedef struct packed {
        logic en;
        logic stat;
    } txg_ctl_t;

    localparam txg_ctl_t TXG_CTL_RST = '{en: 1'b0, stat: 1'b1};

endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_d;
            logic [STAGES-1:0] chain_q;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], din[b]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign dout[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/txg_monitor.sv
module txg_monitor #(
    parameter int CMP_CYC = 4,
    parameter int ENA_CYC = 8,
    parameter int LOW_CYC = 20,
    parameter int REC_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_s,
    input  logic bus_s,
    input  logic hold,
    output logic mis_hit,
    output logic low_hit,
    output logic idle_hit
);

    localparam int MW = $clog2(CMP_CYC + 1);
    localparam int IW = $clog2(ENA_CYC + 1);
    localparam int LW = $clog2(LOW_CYC + 1);
    localparam int HW = $clog2(REC_CYC + 1);

    typedef struct packed {
        logic [MW-1:0] mis;
        logic [IW-1:0] idle;
        logic [LW-1:0] lacc;
        logic [HW-1:0] hi;
        logic          armed;
        logic          tx_prev;
    } mon_t;

    mon_t mon_d, mon_q;

    logic mism, both_hi, fall, rec, timing;

    always_comb begin
        mon_d   = mon_q;
        mism    = tx_s ^ bus_s;
        both_hi = tx_s & bus_s;
        fall    = mon_q.tx_prev & ~tx_s;
        timing  = mon_q.armed | fall;
        rec     = tx_s && (mon_q.hi >= HW'(REC_CYC - 1));

        // hit flags: the current sample completes the window
        mis_hit  = !hold && mism && (mon_q.mis >= MW'(CMP_CYC - 1));
        idle_hit = !hold && both_hi && (mon_q.idle >= IW'(ENA_CYC - 1));
        low_hit  = !hold && timing && !tx_s && (mon_q.lacc >= LW'(LOW_CYC - 1));

        mon_d.tx_prev = tx_s;

        // consecutive mismatch run
        if (hold || !mism)                  mon_d.mis = '0;
        else if (mon_q.mis != MW'(CMP_CYC)) mon_d.mis = mon_q.mis + 1'b1;

        // consecutive idle-high run
        if (hold || !both_hi)                 mon_d.idle = '0;
        else if (mon_q.idle != IW'(ENA_CYC))  mon_d.idle = mon_q.idle + 1'b1;

        // consecutive transmit-high run, used for recovery
        if (hold || !tx_s)                  mon_d.hi = '0;
        else if (mon_q.hi != HW'(REC_CYC))  mon_d.hi = mon_q.hi + 1'b1;

        // accumulated low time since the arming edge
        if (hold || rec) begin
            mon_d.armed = 1'b0;
            mon_d.lacc  = '0;
        end else begin
            if (fall) mon_d.armed = 1'b1;
            if (timing && !tx_s && (mon_q.lacc != LW'(LOW_CYC)))
                mon_d.lacc = mon_q.lacc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_v_s,
    input  logic ovr_val_s,
    input  logic mis_hit,
    input  logic low_hit,
    input  logic idle_hit,
    output logic drv_en,
    output logic status_out
);

    txg_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ovr_v_s) begin
            ctl_d.en = ~ovr_val_s;
        end else if (ctl_q.en) begin
            if (mis_hit || low_hit) ctl_d.en = 1'b0;
        end else begin
            if (idle_hit) ctl_d.en = 1'b1;
        end
        ctl_d.stat = ~ctl_d.en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= TXG_CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign drv_en     = ctl_q.en;
    assign status_out = ctl_q.stat;

endmodule

// File: rtl/txgate_supervisor.sv
module txgate_supervisor
    import txg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CMP_CYC     = 4,
    parameter int ENA_CYC     = 8,
    parameter int LOW_CYC     = 20,
    parameter int REC_CYC     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_in,
    input  logic bus_in,
    input  logic ovr_valid,
    input  logic ovr_value,
    output logic drv_en,
    output logic status_out
);

    txg_in_t raw_in, syn_in;
    logic    tx_s, bus_s, ovr_v_s, ovr_val_s;
    logic    mis_hit, low_hit, idle_hit;

    always_comb begin
        raw_in.tx      = tx_in;
        raw_in.bus     = bus_in;
        raw_in.ovr_v   = ovr_valid;
        raw_in.ovr_val = ovr_value;
    end

    txg_sync #(
        .WIDTH  (TXG_IN_W),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (syn_in)
    );

    assign tx_s      = syn_in.tx;
    assign bus_s     = syn_in.bus;
    assign ovr_v_s   = syn_in.ovr_v;
    assign ovr_val_s = syn_in.ovr_val;

    txg_monitor #(
        .CMP_CYC (CMP_CYC),
        .ENA_CYC (ENA_CYC),
        .LOW_CYC (LOW_CYC),
        .REC_CYC (REC_CYC)
    ) i_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_s     (tx_s),
        .bus_s    (bus_s),
        .hold     (ovr_v_s),
        .mis_hit  (mis_hit),
        .low_hit  (low_hit),
        .idle_hit (idle_hit)
    );

    txg_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovr_v_s    (ovr_v_s),
        .ovr_val_s  (ovr_val_s),
        .mis_hit    (mis_hit),
        .low_hit    (low_hit),
        .idle_hit   (idle_hit),
        .drv_en     (drv_en),
        .status_out (status_out)
    );

endmodule

// File: rtl/txg_checker.sv
module txg_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_s,
    input logic bus_s,
    input logic ovr_v_s,
    input logic ovr_val_s,
    input logic drv_en,
    input logic status_out
);

    // R1: outputs sit in the disabled state while reset is held
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |-> (!drv_en && status_out));

    // R2: status is the inverse of the enable
    assert_status_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_out == !drv_en);

    // R3, R5: a drop without override needs a mismatch or a low transmit sample
    assert_drop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> ($past(ovr_v_s && ovr_val_s) || $past(!tx_s || !bus_s)));

    // R4: a rise without override needs an idle-high sample
    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> ($past(ovr_v_s && !ovr_val_s) || $past(tx_s && bus_s)));

    // R7: a driven override sets the enable on the next edge
    assert_override_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_v_s |=> (drv_en == !$past(ovr_val_s)));

endmodule

bind txgate_supervisor txg_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_s       (tx_s),
    .bus_s      (bus_s),
    .ovr_v_s    (ovr_v_s),
    .ovr_val_s  (ovr_val_s),
    .drv_en     (drv_en),
    .status_out (status_out)
);

// File: tb/test_txgate_supervisor.sv
`timescale 1ns/1ps
module test_txgate_supervisor;

    localparam int CMP = 4;
    localparam int ENA = 8;
    localparam int LOW = 20;
    localparam int REC = 3;
    localparam int SYN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic tx_in = 1'b1, bus_in = 1'b1, ovr_valid = 1'b0, ovr_value = 1'b0;
    logic drv_en, status_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txgate_supervisor #(
        .SYNC_STAGES (SYN), .CMP_CYC (CMP), .ENA_CYC (ENA),
        .LOW_CYC (LOW), .REC_CYC (REC)
    ) i_txgate_supervisor (
        .clk (clk), .rst_n (rst_n), .tx_in (tx_in), .bus_in (bus_in),
        .ovr_valid (ovr_valid), .ovr_value (ovr_value),
        .drv_en (drv_en), .status_out (status_out)
    );

    // {tx, bus, ovr_valid, ovr_value, cycles[7:0], expected drv_en}
    localparam logic [12:0] VEC [10] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd14, 1'b1},  // R4 idle enables
        {1'b0, 1'b1, 1'b0, 1'b0, 8'd10, 1'b0},  // R3 tx low, bus high
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd14, 1'b1},  // R4
        {1'b1, 1'b0, 1'b0, 1'b0, 8'd10, 1'b0},  // R3 tx high, bus low
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd14, 1'b1},  // R4
        {1'b0, 1'b1, 1'b1, 1'b0, 8'd10, 1'b1},  // R7 forced on under mismatch
        {1'b1, 1'b1, 1'b1, 1'b1, 8'd10, 1'b0},  // R7 forced off while idle
        {1'b1, 1'b1, 1'b1, 1'b0, 8'd6,  1'b1},  // R7 forced on
        {1'b0, 1'b0, 1'b0, 1'b0, 8'd30, 1'b0},  // R5 stuck low after release
        {1'b1, 1'b1, 1'b0, 1'b0, 8'd14, 1'b1}   // R4
    };

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic t, input logic b, input logic ov, input logic oval);
        tx_in = t; bus_in = b; ovr_valid = ov; ovr_value = oval;
    endtask

    task automatic check(input string tag, input logic exp);
        checks++;
        if (drv_en !== exp) begin
            errors++;
            $display("FAIL %s drv_en actual=%0b expected=%0b", tag, drv_en, exp);
        end
        checks++;
        if (status_out !== !exp) begin
            errors++;
            $display("FAIL R2 (%s) status_out actual=%0b expected=%0b", tag, status_out, !exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        drive(1, 1, 0, 0);
        hold(3);
        check("R1 during reset", 1'b0);
        rst_n = 1'b1;
        check("R1 after release", 1'b0);
        hold(SYN + ENA - 1);
        check("R1/R4 idle window not yet complete", 1'b0);
        hold(2);
        check("R4 enabled after idle window", 1'b1);

        // table walk
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9]);
            hold(int'(VEC[i][8:1]));
            check($sformatf("table[%0d] R3/R4/R5/R7", i), VEC[i][0]);
        end

        // R9: override latency
        drive(1, 1, 1, 1);
        hold(SYN);
        check("R9 before third edge", 1'b1);
        hold(1);
        check("R9 on third edge", 1'b0);
        // R8: release with idle keeps disabled, idle window restarts
        drive(1, 1, 0, 0);
        hold(SYN + ENA - 1);
        check("R8 state kept after release", 1'b0);
        hold(2);
        check("R8 enable after fresh window", 1'b1);

        // R3 boundary
        drive(0, 1, 0, 0); hold(CMP - 1);
        drive(1, 1, 0, 0); hold(6);
        check("R3 short mismatch ignored", 1'b1);
        drive(0, 1, 0, 0); hold(CMP);
        drive(1, 1, 0, 0); hold(4);
        check("R3 full mismatch disables", 1'b0);
        hold(10);
        check("R4 re-enable after mismatch", 1'b1);

        // R4 boundary
        drive(0, 1, 0, 0); hold(6);
        drive(1, 1, 0, 0); hold(ENA - 1);
        drive(0, 0, 0, 0); hold(4);
        check("R4 short idle insufficient", 1'b0);
        drive(1, 1, 0, 0); hold(ENA);
        drive(0, 0, 0, 0); hold(4);
        check("R4 full idle enables", 1'b1);
        drive(1, 1, 0, 0); hold(6);

        // R5 boundary
        drive(0, 0, 0, 0); hold(LOW - 1);
        drive(1, 1, 0, 0); hold(6);
        check("R5 short low ignored", 1'b1);
        drive(0, 0, 0, 0); hold(LOW);
        drive(1, 1, 0, 0); hold(3);
        check("R5 stuck low disables", 1'b0);
        hold(10);
        check("R5 re-enable after idle", 1'b1);

        // R6 recovery width
        drive(0, 0, 0, 0); hold(12);
        drive(1, 1, 0, 0); hold(REC - 1);
        drive(0, 0, 0, 0); hold(LOW - 12);
        drive(1, 1, 0, 0); hold(3);
        check("R6 short high keeps low time", 1'b0);
        hold(10);
        check("R6 re-enable", 1'b1);
        drive(0, 0, 0, 0); hold(12);
        drive(1, 1, 0, 0); hold(REC);
        drive(0, 0, 0, 0); hold(LOW - 12);
        drive(1, 1, 0, 0); hold(6);
        check("R6 full recovery clears timer", 1'b1);

        // R8: release with persisting mismatch
        drive(0, 1, 1, 0); hold(10);
        check("R7 forced on under mismatch", 1'b1);
        drive(0, 1, 0, 0); hold(SYN + CMP - 1);
        check("R8 mismatch window restarts at release", 1'b1);
        hold(2);
        check("R8 mismatch disables after full window", 1'b0);
        drive(1, 1, 0, 0); hold(14);
        check("R4 final re-enable", 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule